// File: doc/BRIEF.md
# Command-Word I2C Register Bridge

This block turns one five-byte control word into a single-register transaction on an I2C bus, aimed at an external clock-synthesizer chip. A word arrives as a one-cycle strobe with a command-address byte, a flag that asks for a response, and four payload bytes. If the address matches and the first payload byte is a known operation code, the block either writes one data byte into one device register or reads one device register back. A built-in bit-level master drives the open-drain SCL and SDA lines.

The second payload byte packs two things: a stop-enable flag in its top bit and the 7-bit device address in its low bits. The third byte names the device register. The fourth byte is the data for a write and is ignored for a read. When a response is requested, the block reports the read byte, or zero for a write, together with an error flag. The error flag is set if the device failed to acknowledge.

Top module: `ctlb_i2c_bridge`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `busy`, `resp_valid`, `scl_oe` and `sda_oe` are 0.
- R2: A strobe on `cmd_valid` is accepted only when `cmd_addr` equals parameter `CMD_ADDR` (default 0x3c) and `cmd_op` is 0x06 (write) or 0x07 (read). Any other word leaves `busy` low and the bus untouched.
- R3: A write runs START, address byte `{cmd_dev[6:0],0}`, `cmd_reg`, `cmd_data`, STOP, and leaves `cmd_data` in device register `cmd_reg`. The bus shows exactly one START.
- R4: A read runs START, `{cmd_dev[6:0],0}`, `cmd_reg`, repeated START, `{cmd_dev[6:0],1}`, then one data byte. The bus shows two STARTs. The byte is returned on `resp_data` with `resp_err`=0.
- R5: `resp_valid` pulses for exactly one cycle, in the cycle `busy` first reads low, and only for accepted commands with `cmd_resp_req`=1. A write reports `resp_data`=0.
- R6: If any address or written byte is not acknowledged, the transfer goes straight to STOP. The response then carries `resp_err`=1 and `resp_data`=0, both lines are released, and no later byte is sent.
- R7: `busy` rises only in the cycle after an accepted strobe and stays high until the transfer has finished. Strobes during `busy` are ignored. While `busy` stays low, `scl_oe` and `sda_oe` do not change.
- R8: When `cmd_dev[7]` is 0, no STOP is sent and SCL stays driven low (`scl_oe`=1) after `busy` falls. A later command still completes normally.
- R9: Each SCL high phase inside a transfer lasts 2*QDIV system cycles, where QDIV = CLK_HZ/(4*SCL_HZ).
- R10: The master answers the single read data byte with NACK, leaving SDA released on the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_addr | input | 8 | Command address byte, compared with CMD_ADDR |
| cmd_resp_req | input | 1 | 1 asks for a response |
| cmd_op | input | 8 | Operation code: 0x06 write, 0x07 read |
| cmd_dev | input | 8 | Bit 7 stop enable, bits 6:0 device address |
| cmd_reg | input | 8 | Device register address |
| cmd_data | input | 8 | Write data, ignored for reads |
| busy | output | 1 | Transfer in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_err | output | 1 | 1 when a byte was not acknowledged |
| resp_data | output | 8 | Read byte, 0 for writes and errors |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
`busy` is due at the first falling clock edge after the accepting rising edge, and the bench checks it there. A response lands in the very cycle `busy` first reads low. That moment drifts with the free-running quarter-bit tick, so it is not fixed relative to the strobe. For this reason a monitor compares every `resp_valid` against a queue of expected responses rather than at a fixed cycle count. Register contents, START/STOP counts and the read acknowledge bit come from a bus-level device model. They are examined only after `busy` has fallen. SCL high phases are timed in cycles by a separate sampler on falling clock edges.

// File: rtl/ctlb_pkg.sv
package ctlb_pkg;
   localparam logic [7:0] OP_WRITE = 8'h06;
   localparam logic [7:0] OP_READ  = 8'h07;

   typedef enum logic [1:0] {
      PHY_START,
      PHY_RSTART,
      PHY_BYTE,
      PHY_STOP
   } phy_op_e;
endpackage

// File: rtl/ctlb_tick_gen.sv
module ctlb_tick_gen #(
   parameter int QDIV = 62
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= (cnt == LAST);
         cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ctlb_in_sync.sv
module ctlb_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2+1-1:0], d} >> 0;
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ctlb_i2c_phy.sv
module ctlb_i2c_phy
   import ctlb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       op_valid,
   input  phy_op_e    op,
   input  logic [8:0] op_tx,
   input  logic       sda_in,
   output logic       done,
   output logic [8:0] rx,
   output logic       scl_low,
   output logic       sda_low
);
   typedef enum logic [2:0] {P_IDLE, P_START, P_RSTART, P_BIT, P_STOP} pst_e;

   pst_e       st;
   logic [1:0] q;
   logic [3:0] bitn;
   logic [8:0] tx;
   logic       scl_nx, sda_nx, last_q;

   function automatic pst_e op_to_state(phy_op_e o);
      case (o)
         PHY_START:  return P_START;
         PHY_RSTART: return P_RSTART;
         PHY_BYTE:   return P_BIT;
         default:    return P_STOP;
      endcase
   endfunction

   // Line levels for the quarter being entered on the next tick
   always_comb begin
      scl_nx = scl_low;
      sda_nx = sda_low;
      last_q = 1'b0;
      case (st)
         P_START:  begin scl_nx = (q == 2'd2);                sda_nx = (q != 2'd0); last_q = (q == 2'd2); end
         P_RSTART: begin scl_nx = (q == 2'd0) || (q == 2'd3); sda_nx = (q >= 2'd2); last_q = (q == 2'd3); end
         P_BIT:    begin scl_nx = (q == 2'd0) || (q == 2'd3); sda_nx = ~tx[8];      last_q = (q == 2'd3); end
         P_STOP:   begin scl_nx = (q == 2'd0);                sda_nx = (q != 2'd2); last_q = (q == 2'd2); end
         default:  ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= P_IDLE;
         q       <= '0;
         bitn    <= '0;
         tx      <= '1;
         rx      <= '0;
         scl_low <= 1'b0;
         sda_low <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (st == P_IDLE) begin
            if (op_valid) begin
               st   <= op_to_state(op);
               q    <= '0;
               bitn <= '0;
               tx   <= op_tx;
            end
         end else if (tick) begin
            scl_low <= scl_nx;
            sda_low <= sda_nx;
            if (st == P_BIT && q == 2'd2) rx <= {rx[7:0], sda_in};
            if (last_q) begin
               q <= '0;
               if (st == P_BIT && bitn != 4'd8) begin
                  bitn <= bitn + 1'b1;
                  tx   <= {tx[7:0], 1'b1};
               end else begin
                  st   <= P_IDLE;
                  done <= 1'b1;
               end
            end else begin
               q <= q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ctlb_i2c_bridge.sv
module ctlb_i2c_bridge
   import ctlb_pkg::*;
#(
   parameter int         CLK_HZ      = 100_000_000,
   parameter int         SCL_HZ      = 400_000,
   parameter logic [7:0] CMD_ADDR    = 8'h3c,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_addr,
   input  logic       cmd_resp_req,
   input  logic [7:0] cmd_op,
   input  logic [7:0] cmd_dev,
   input  logic [7:0] cmd_reg,
   input  logic [7:0] cmd_data,
   output logic       busy,
   output logic       resp_valid,
   output logic       resp_err,
   output logic [7:0] resp_data,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic       sda_i
);
   localparam int QDIV = CLK_HZ / (4 * SCL_HZ);

   generate
      if (SCL_HZ <= 0 || QDIV < SYNC_STAGES + 3) begin : g_bad_rate
         $error("ctlb_i2c_bridge: quarter-bit divider too small for the input synchronizer");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("ctlb_i2c_bridge: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   typedef enum logic [3:0] {
      S_IDLE, S_START, S_ADW, S_REG, S_DATA, S_RSTART, S_ADR, S_RD, S_STOP, S_FIN
   } seq_e;

   seq_e       step;
   logic       issued, is_rd, stop_en, rreq, err;
   logic [6:0] dev;
   logic [7:0] regad, wdat, rdat;
   logic       tick, sda_s, op_valid, done, nack;
   phy_op_e    op;
   logic [8:0] op_tx, rx;
   logic       accept;

   ctlb_tick_gen #(.QDIV(QDIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

   ctlb_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
   );

   ctlb_i2c_phy u_phy (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .op_valid(op_valid), .op(op), .op_tx(op_tx), .sda_in(sda_s),
      .done(done), .rx(rx), .scl_low(scl_oe), .sda_low(sda_oe)
   );

   assign busy   = (step != S_IDLE);
   assign accept = cmd_valid && !busy && (cmd_addr == CMD_ADDR) &&
                   ((cmd_op == OP_WRITE) || (cmd_op == OP_READ));
   assign nack   = rx[0];

   always_comb begin
      op    = PHY_BYTE;
      op_tx = 9'h1FF;
      case (step)
         S_START:  op = PHY_START;
         S_ADW:    op_tx = {dev, 1'b0, 1'b1};
         S_REG:    op_tx = {regad, 1'b1};
         S_DATA:   op_tx = {wdat, 1'b1};
         S_RSTART: op = PHY_RSTART;
         S_ADR:    op_tx = {dev, 1'b1, 1'b1};
         S_STOP:   op = PHY_STOP;
         default:  ;
      endcase
      op_valid = !issued && (step != S_IDLE) && (step != S_FIN);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step       <= S_IDLE;
         issued     <= 1'b0;
         is_rd      <= 1'b0;
         stop_en    <= 1'b0;
         rreq       <= 1'b0;
         err        <= 1'b0;
         dev        <= '0;
         regad      <= '0;
         wdat       <= '0;
         rdat       <= '0;
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_data  <= '0;
      end else begin
         resp_valid <= 1'b0;
         if (op_valid) issued <= 1'b1;
         if (accept) begin
            step    <= S_START;
            is_rd   <= (cmd_op == OP_READ);
            stop_en <= cmd_dev[7];
            dev     <= cmd_dev[6:0];
            regad   <= cmd_reg;
            wdat    <= cmd_data;
            rreq    <= cmd_resp_req;
            err     <= 1'b0;
            rdat    <= '0;
         end else if (step == S_FIN) begin
            step       <= S_IDLE;
            resp_valid <= rreq;
            resp_err   <= err;
            resp_data  <= (is_rd && !err) ? rdat : 8'h00;
         end else if (done) begin
            issued <= 1'b0;
            case (step)
               S_START:  step <= S_ADW;
               S_RSTART: step <= S_ADR;
               S_STOP:   step <= S_FIN;
               S_RD: begin
                  rdat <= rx[8:1];
                  step <= stop_en ? S_STOP : S_FIN;
               end
               default: begin
                  if (nack) begin
                     err  <= 1'b1;
                     step <= S_STOP;
                  end else begin
                     case (step)
                        S_ADW:   step <= S_REG;
                        S_REG:   step <= is_rd ? S_RSTART : S_DATA;
                        S_ADR:   step <= S_RD;
                        default: step <= stop_en ? S_STOP : S_FIN;
                     endcase
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/ctlb_i2c_bridge_chk.sv
module ctlb_i2c_bridge_chk #(
   parameter logic [7:0] CMD_ADDR = 8'h3c
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [7:0] cmd_addr,
   input logic       busy,
   input logic       resp_valid,
   input logic       resp_err,
   input logic       scl_oe,
   input logic       sda_oe
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!busy && !resp_valid && !scl_oe && !sda_oe));

   assert_foreign_addr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && cmd_addr != CMD_ADDR) |=> !busy);

   assert_resp_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> $fell(busy));

   assert_resp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   assert_err_releases_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_err) |-> (!scl_oe && !sda_oe));

   assert_busy_from_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid));

   assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> ($stable(scl_oe) && $stable(sda_oe)));
endmodule

bind ctlb_i2c_bridge ctlb_i2c_bridge_chk #(.CMD_ADDR(CMD_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
   .busy(busy), .resp_valid(resp_valid), .resp_err(resp_err),
   .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/ctlb_i2c_bridge_tb.sv
module ctlb_i2c_bridge_tb;
   localparam int CLK_HZ = 100_000_000;
   localparam int SCL_HZ = 5_000_000;
   localparam int QDIV   = CLK_HZ / (4 * SCL_HZ);
   localparam logic [6:0] DEV = 7'h6a;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_resp_req = 1'b0;
   logic [7:0] cmd_addr = 8'h00, cmd_op = 8'h00, cmd_dev = 8'h00, cmd_reg = 8'h00, cmd_data = 8'h00;
   logic busy, resp_valid, resp_err, scl_oe, sda_oe;
   logic [7:0] resp_data;
   logic slv_low;

   wire scl_line = !scl_oe;
   wire sda_line = !(sda_oe || slv_low);

   always #5 clk = ~clk;

   ctlb_i2c_bridge #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
      .cmd_resp_req(cmd_resp_req), .cmd_op(cmd_op), .cmd_dev(cmd_dev),
      .cmd_reg(cmd_reg), .cmd_data(cmd_data), .busy(busy), .resp_valid(resp_valid),
      .resp_err(resp_err), .resp_data(resp_data), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .sda_i(sda_line)
   );

   int checks = 0, failures = 0, resp_seen = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // ---------------- device model ----------------
   typedef enum int {SL_IDLE, SL_RX, SL_ACK, SL_TX, SL_MACK} sl_e;
   sl_e sst;
   logic [7:0] mem [256];
   logic [7:0] sh, ptr, txb;
   int bcnt, nbyte, starts, stops, nack_at = -1;
   bit rw, pscl, psda, last_mack, ack_v;

   always @(negedge clk) begin
      if (!rst_n) begin
         sst <= SL_IDLE; slv_low <= 1'b0; pscl <= 1'b1; psda <= 1'b1;
         starts <= 0; stops <= 0; bcnt <= 0; nbyte <= 0; rw <= 1'b0;
         sh <= 8'h00; ptr <= 8'h00; txb <= 8'h00; last_mack <= 1'b0;
         for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      end else begin
         pscl <= scl_line; psda <= sda_line;
         if (pscl && scl_line && psda && !sda_line) begin
            sst <= SL_RX; bcnt <= 0; nbyte <= 0; slv_low <= 1'b0; starts <= starts + 1;
         end else if (pscl && scl_line && !psda && sda_line) begin
            sst <= SL_IDLE; slv_low <= 1'b0; stops <= stops + 1;
         end else if (!pscl && scl_line) begin
            if (sst == SL_RX) begin sh <= {sh[6:0], sda_line}; bcnt <= bcnt + 1; end
            if (sst == SL_MACK) last_mack <= sda_line;
         end else if (pscl && !scl_line) begin
            case (sst)
               SL_RX: if (bcnt == 8) begin
                  ack_v = 1'b1;
                  if (nbyte == 0) begin
                     if (sh[7:1] != DEV) ack_v = 1'b0;
                     rw <= sh[0];
                  end
                  if (nbyte == nack_at) ack_v = 1'b0;
                  if (ack_v && nbyte == 1) ptr <= sh;
                  if (ack_v && nbyte >= 2) begin mem[ptr] <= sh; ptr <= ptr + 1; end
                  slv_low <= ack_v;
                  sst <= ack_v ? SL_ACK : SL_IDLE;
               end
               SL_ACK: begin
                  bcnt <= 0; nbyte <= nbyte + 1;
                  if (rw && nbyte == 0) begin
                     txb <= mem[ptr]; slv_low <= !mem[ptr][7]; sst <= SL_TX;
                  end else begin
                     slv_low <= 1'b0; sst <= SL_RX;
                  end
               end
               SL_TX: begin
                  bcnt <= bcnt + 1;
                  if (bcnt == 7) begin slv_low <= 1'b0; sst <= SL_MACK; end
                  else slv_low <= !txb[6-bcnt];
               end
               SL_MACK: sst <= SL_IDLE;
               default: ;
            endcase
         end
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct { bit err; logic [7:0] data; string tag; } exp_t;
   exp_t expq[$];

   always @(negedge clk) begin
      if (rst_n && resp_valid) begin
         resp_seen++;
         if (expq.size() == 0) begin
            chk(1'b0, "R5", "unexpected response", 1, 0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            chk(resp_err == e.err, e.tag, "resp_err", resp_err, e.err);
            chk(resp_data == e.data, e.tag, "resp_data", resp_data, e.data);
         end
      end
   end

   // ---------------- SCL high-phase timing (R9) ----------------
   int run = 0, pulses = 0, bad_pulses = 0;
   bit prev_scl = 1'b1, run_idle = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (scl_line && !prev_scl) begin run = 1; run_idle = !busy; end
         else if (scl_line) begin run++; run_idle |= !busy; end
         else if (prev_scl && run > 0 && !run_idle) begin
            pulses++;
            if (run != 2 * QDIV) bad_pulses++;
         end
         prev_scl = scl_line;
      end
   end

   // ---------------- driver ----------------
   task automatic send(input logic [7:0] a, input bit rq, input logic [7:0] o, d, r, v,
                       input bit exp_acc, input bit exp_err, input logic [7:0] exp_data,
                       input string tag);
      if (exp_acc && rq) begin
         exp_t e;
         e.err = exp_err; e.data = exp_data; e.tag = tag;
         expq.push_back(e);
      end
      @(negedge clk);
      cmd_valid = 1'b1; cmd_addr = a; cmd_resp_req = rq;
      cmd_op = o; cmd_dev = d; cmd_reg = r; cmd_data = v;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int s0, p0, r0;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(!busy && !resp_valid && !scl_oe && !sda_oe, "R1", "idle outputs in reset",
          {busy, resp_valid, scl_oe, sda_oe}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !scl_oe && !sda_oe, "R1", "idle outputs after reset", {busy, scl_oe, sda_oe}, 0);

      // R3 write with response
      s0 = starts; p0 = stops;
      send(8'h3c, 1, 8'h06, 8'hea, 8'h17, 8'h04, 1, 0, 8'h00, "R3");
      chk(busy == 1'b1, "R7", "busy after accept", busy, 1);
      wait_idle();
      chk(mem[8'h17] == 8'h04, "R3", "register 0x17", mem[8'h17], 8'h04);
      chk(starts - s0 == 1, "R3", "start count", starts - s0, 1);
      chk(stops - p0 == 1, "R3", "stop count", stops - p0, 1);

      // R4 read back, with repeated start and NACK on data (R10)
      s0 = starts;
      send(8'h3c, 1, 8'h07, 8'hea, 8'h17, 8'hff, 1, 0, 8'h04, "R4");
      wait_idle();
      chk(starts - s0 == 2, "R4", "start count", starts - s0, 2);
      chk(last_mack == 1'b1, "R10", "master ack bit on read", last_mack, 1);

      // R3/R4 second pattern
      send(8'h3c, 1, 8'h06, 8'hea, 8'h2d, 8'ha5, 1, 0, 8'h00, "R3");
      wait_idle();
      send(8'h3c, 1, 8'h07, 8'hea, 8'h2d, 8'h00, 1, 0, 8'ha5, "R4");
      wait_idle();

      // R5 no response requested
      r0 = resp_seen;
      send(8'h3c, 0, 8'h06, 8'hea, 8'h60, 8'h3b, 1, 0, 8'h00, "R5");
      wait_idle();
      send(8'h3c, 0, 8'h07, 8'hea, 8'h60, 8'h00, 1, 0, 8'h00, "R5");
      wait_idle();
      chk(resp_seen == r0, "R5", "responses without request", resp_seen - r0, 0);
      chk(mem[8'h60] == 8'h3b, "R3", "register 0x60", mem[8'h60], 8'h3b);

      // R2 ignored words
      send(8'h3c, 1, 8'h05, 8'hea, 8'h61, 8'h55, 0, 0, 8'h00, "R2");
      repeat (3 * QDIV) @(negedge clk);
      chk(!busy && !scl_oe && !sda_oe, "R2", "bad op code ignored", {busy, scl_oe, sda_oe}, 0);
      send(8'h3d, 1, 8'h06, 8'hea, 8'h61, 8'h55, 0, 0, 8'h00, "R2");
      repeat (3 * QDIV) @(negedge clk);
      chk(!busy && !scl_oe && !sda_oe, "R2", "foreign address ignored", {busy, scl_oe, sda_oe}, 0);
      chk(mem[8'h61] == 8'h00, "R2", "register 0x61 untouched", mem[8'h61], 0);

      // R7 command during busy ignored
      send(8'h3c, 1, 8'h06, 8'hea, 8'h40, 8'h11, 1, 0, 8'h00, "R7");
      repeat (3) @(negedge clk);
      send(8'h3c, 1, 8'h06, 8'hea, 8'h40, 8'h99, 0, 0, 8'h00, "R7");
      wait_idle();
      chk(mem[8'h40] == 8'h11, "R7", "register 0x40", mem[8'h40], 8'h11);

      // R6 address NACK
      p0 = stops;
      send(8'h3c, 1, 8'h06, 8'hd5, 8'h41, 8'h22, 1, 1, 8'h00, "R6");
      wait_idle();
      chk(!scl_oe && !sda_oe, "R6", "bus released after address nack", {scl_oe, sda_oe}, 0);
      chk(stops - p0 == 1, "R6", "stop after nack", stops - p0, 1);
      chk(mem[8'h41] == 8'h00, "R6", "register 0x41 untouched", mem[8'h41], 0);

      // R6 data NACK on a read's register byte, then on a write's data byte
      nack_at = 1;
      send(8'h3c, 1, 8'h07, 8'hea, 8'h17, 8'h00, 1, 1, 8'h00, "R6");
      wait_idle();
      nack_at = 2;
      send(8'h3c, 1, 8'h06, 8'hea, 8'h50, 8'h77, 1, 1, 8'h00, "R6");
      wait_idle();
      nack_at = -1;
      chk(mem[8'h50] == 8'h00, "R6", "register 0x50 untouched", mem[8'h50], 0);
      chk(!scl_oe && !sda_oe, "R6", "bus released after data nack", {scl_oe, sda_oe}, 0);

      // R8 no stop
      p0 = stops;
      send(8'h3c, 1, 8'h06, 8'h6a, 8'h21, 8'h0c, 1, 0, 8'h00, "R8");
      wait_idle();
      chk(scl_oe == 1'b1, "R8", "SCL held low without stop", scl_oe, 1);
      chk(stops == p0, "R8", "no stop seen", stops - p0, 0);
      send(8'h3c, 1, 8'h07, 8'hea, 8'h21, 8'h00, 1, 0, 8'h0c, "R8");
      wait_idle();
      chk(!scl_oe && !sda_oe, "R8", "bus released after follow-up", {scl_oe, sda_oe}, 0);

      // R9 SCL timing and R5 drained queue
      chk(pulses > 0 && bad_pulses == 0, "R9", "SCL high phases off 2*QDIV", bad_pulses, 0);
      chk(expq.size() == 0, "R5", "responses outstanding", expq.size(), 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule